// File: doc/BRIEF.md
# Context Admin Queue Executor

This block is the command engine that software uses to set up and inspect the per-queue contexts of a network interface. Software places fixed-size two-word instructions in an instruction ring, rings a doorbell with the number of new entries, and the engine works through them in order. Each instruction names an operation, a context type and a context index. The engine runs it against an internal context store that holds separate tables for receive, send and completion queue contexts and for hash-steering entries. Every instruction leaves a result record in a result buffer. The result buffer and the instruction ring are modelled as on-chip word memories.

The result record starts with a header word. Context data supplied by software for initialise and masked-write operations, and context data returned by reads, sit 16 words (128 bytes) after the header. The bit mask for a masked write sits 32 words (256 bytes) after it. The engine first stamps the header with a not-done code, then carries out the operation, then writes the final completion code. If the instruction asked for it, the engine raises a one-cycle interrupt pulse.

Top module: `ctx_aq_engine`

## Requirements
- R1: Instruction word 0 is decoded as opcode in bits [3:0], context type in [7:4], context index in [43:24] and the interrupt-request flag in bit 63. Bits [14:8] (the issuing function number) and every other bit are ignored. Word 1 is a byte address, and the header sits at the 64-bit word with index word1[3+RW-1:3]. Opcodes: 0 no-op, 1 initialise, 2 masked write, 3 read, 4 lock, 5 unlock.
- R2: After reset, busy, head_ptr, pend_cnt and done_irq are 0. While the engine is idle and pend_cnt is nonzero, it takes one instruction at the next edge. busy is then high for exactly three cycles (stamp, execute, finish), and the engine is idle for at least one cycle before the next instruction.
- R3: One edge after the engine takes an instruction, the header word holds the instruction's opcode and type with completion code 0 (not done). It keeps that value until the finish edge.
- R4: The final header word is {47'b0, irq flag in bit 16, completion code in [15:8], context type in [7:4], opcode in [3:0]}. Code 1 means good and code 2 means software error.
- R5: An initialise with a legal type and index copies the word at header+16 into the selected context, marks the context valid and completes with code 1.
- R6: A masked write to a valid context replaces only the bits set in the mask word at header+32 with the bits of the data word at header+16, and completes with code 1.
- R7: A read of a valid context writes that context to the word at header+16 and completes with code 1.
- R8: A masked write or read to a context never initialised, an undefined opcode, an unheld context type, or an index at or above CTX_NUM completes with code 2. It changes neither the context store nor the data word at header+16.
- R9: No-op, lock and unlock complete with code 1 and change no context.
- R10: done_irq is high for exactly one cycle, the cycle after the finish edge, and only when the instruction's irq flag is set.
- R11: The instruction is fetched from ring slot (cfg_ring_base + head_ptr) mod INST_DEPTH. On each take, head_ptr advances and wraps to 0 when head_ptr+1 reaches cfg_ring_size. A doorbell adds db_count to pend_cnt, and in a cycle that also takes an instruction the net change is db_count-1.
- R12: Types 0 (receive), 1 (send), 2 (completion) and 4 (hash steering) each have their own table of CTX_NUM entries. Type 3, type 5 and all higher codes are not held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_ring_base | input | IW | First ring slot in instruction memory |
| cfg_ring_size | input | IW+1 | Ring length in entries |
| db_valid | input | 1 | Doorbell strobe |
| db_count | input | PEND_W | Instructions added by the doorbell |
| inst_wr_en | input | 1 | Instruction memory write strobe |
| inst_wr_idx | input | IW | Instruction memory slot |
| inst_wr_w0 | input | 64 | Instruction word 0 |
| inst_wr_w1 | input | 64 | Instruction word 1 (result byte address) |
| res_wr_en | input | 1 | Result memory software write strobe |
| res_wr_addr | input | RW | Result memory word address for writes |
| res_wr_data | input | 64 | Result memory write data |
| res_rd_addr | input | RW | Result memory word address for reads |
| res_rd_data | output | 64 | Result memory read data, combinational |
| busy | output | 1 | Engine is working on an instruction |
| head_ptr | output | IW | Ring head offset |
| pend_cnt | output | PEND_W | Instructions waiting |
| done_irq | output | 1 | Completion interrupt pulse |

## Verification
The bench builds the engine with INST_DEPTH 8 and CTX_NUM 4, and keeps 64 result words and an 8-bit pending counter. With an 8-slot memory, a ring of 3 entries placed at slot 6 spills past the end of the memory, so both the slot wrap and the head wrap occur within a few instructions. Four entries per table put index 3 (the last legal one) and index 4 (the first illegal one, which would alias entry 0 if the index were truncated) within a short run. Doorbells that arrive while the engine is busy, and back-to-back batches, exercise the pending count together with each take.

// File: rtl/ctx_aq_pkg.sv
package ctx_aq_pkg;

  localparam logic [3:0] OP_NOP    = 4'd0;
  localparam logic [3:0] OP_INIT   = 4'd1;
  localparam logic [3:0] OP_WRITE  = 4'd2;
  localparam logic [3:0] OP_READ   = 4'd3;
  localparam logic [3:0] OP_LOCK   = 4'd4;
  localparam logic [3:0] OP_UNLOCK = 4'd5;

  localparam logic [7:0] CC_NOTDONE = 8'd0;
  localparam logic [7:0] CC_GOOD    = 8'd1;
  localparam logic [7:0] CC_SWERR   = 8'd2;

  // word offsets of the data and mask words behind a result header
  localparam int DATA_OFS = 16;
  localparam int MASK_OFS = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STAMP,
    ST_EXEC,
    ST_FIN
  } aq_state_e;

  typedef struct packed {
    logic        irq_req;
    logic [19:0] cidx;
    logic [3:0]  ctype;
    logic [3:0]  opc;
  } aq_cmd_t;

  function automatic logic [63:0] mk_header(input logic [3:0] opc, input logic [3:0] ctype,
                                            input logic [7:0] code, input logic irq_req);
    return {47'd0, irq_req, code, ctype, opc};
  endfunction

endpackage

// File: rtl/aq_ring_ctrl.sv
module aq_ring_ctrl #(
  parameter int IW = 4,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW:0]   ring_size,
  input  logic          db_valid,
  input  logic [PW-1:0] db_count,
  input  logic          take,
  output logic [IW-1:0] head,
  output logic [PW-1:0] pend
);

  logic [IW-1:0] head_q, head_d;
  logic [PW-1:0] pend_q, pend_d;
  logic [IW:0]   head_inc;

  always_comb begin
    head_inc = {1'b0, head_q} + (IW+1)'(1);
    head_d   = head_q;
    if (take) begin
      head_d = (head_inc >= ring_size) ? '0 : head_inc[IW-1:0];
    end
    pend_d = pend_q;
    if (db_valid) pend_d = pend_d + db_count;
    if (take)     pend_d = pend_d - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      pend_q <= '0;
    end else begin
      if (take)             head_q <= head_d;
      if (db_valid || take) pend_q <= pend_d;
    end
  end

  assign head = head_q;
  assign pend = pend_q;

endmodule

// File: rtl/aq_ctx_store.sv
module aq_ctx_store #(
  parameter int  CTX_NUM = 8,
  parameter int  NTAB    = 4,
  localparam int CW      = $clog2(CTX_NUM),
  localparam int SW      = $clog2(NTAB),
  localparam int ENTRIES = NTAB * CTX_NUM,
  localparam int AW      = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  input  logic [CW-1:0] idx,
  output logic [63:0]   rd_data,
  output logic          rd_valid,
  input  logic          we,
  input  logic [63:0]   wr_data
);

  logic [63:0]        mem [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_d;
  logic [AW-1:0]      addr;

  assign addr     = AW'(sel) * AW'(CTX_NUM) + AW'(idx);
  assign rd_data  = mem[addr];
  assign rd_valid = valid_q[addr];

  always_comb begin
    valid_d = valid_q;
    if (we) valid_d[addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  valid_q <= '0;
    else if (we) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wr_data;
  end

endmodule

// File: rtl/aq_result_ram.sv
module aq_result_ram #(
  parameter int  DEPTH = 64,
  parameter int  NRD   = 3,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    sw_we,
  input  logic [AW-1:0]           sw_addr,
  input  logic [63:0]             sw_data,
  input  logic                    eng_we,
  input  logic [AW-1:0]           eng_addr,
  input  logic [63:0]             eng_data,
  input  logic [NRD-1:0][AW-1:0]  rd_addr,
  output logic [NRD-1:0][63:0]    rd_data
);

  logic [63:0] mem [DEPTH];

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end

  // the engine has priority over software on a shared cycle
  always_ff @(posedge clk) begin
    if (eng_we)     mem[eng_addr] <= eng_data;
    else if (sw_we) mem[sw_addr]  <= sw_data;
  end

endmodule

// File: rtl/ctx_aq_engine.sv
module ctx_aq_engine
  import ctx_aq_pkg::*;
#(
  parameter int  INST_DEPTH = 16,
  parameter int  CTX_NUM    = 8,
  parameter int  RES_DEPTH  = 64,
  parameter int  PEND_W     = 8,
  localparam int IW         = $clog2(INST_DEPTH),
  localparam int RW         = $clog2(RES_DEPTH),
  localparam int CW         = $clog2(CTX_NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     cfg_ring_base,
  input  logic [IW:0]       cfg_ring_size,
  input  logic              db_valid,
  input  logic [PEND_W-1:0] db_count,
  input  logic              inst_wr_en,
  input  logic [IW-1:0]     inst_wr_idx,
  input  logic [63:0]       inst_wr_w0,
  input  logic [63:0]       inst_wr_w1,
  input  logic              res_wr_en,
  input  logic [RW-1:0]     res_wr_addr,
  input  logic [63:0]       res_wr_data,
  input  logic [RW-1:0]     res_rd_addr,
  output logic [63:0]       res_rd_data,
  output logic              busy,
  output logic [IW-1:0]     head_ptr,
  output logic [PEND_W-1:0] pend_cnt,
  output logic              done_irq
);

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  // instruction ring memory, only decoded fields kept
  aq_cmd_t       cmd_mem [INST_DEPTH];
  logic [RW-1:0] ra_mem  [INST_DEPTH];
  logic          unused_inst_bits;

  assign unused_inst_bits = ^{inst_wr_w0[62:44], inst_wr_w0[23:8],
                              inst_wr_w1[63:RW+3], inst_wr_w1[2:0]};

  always_ff @(posedge clk) begin
    if (inst_wr_en) begin
      cmd_mem[inst_wr_idx] <= '{irq_req: inst_wr_w0[63], cidx: inst_wr_w0[43:24],
                                ctype: inst_wr_w0[7:4], opc: inst_wr_w0[3:0]};
      ra_mem[inst_wr_idx]  <= inst_wr_w1[RW+2:3];
    end
  end

  // ring pointers
  aq_state_e     state_q, state_d;
  logic          take;
  logic [IW-1:0] slot;

  assign take = (state_q == ST_IDLE) && (pend_cnt != '0);
  assign slot = cfg_ring_base + head_ptr;

  aq_ring_ctrl #(.IW(IW), .PW(PEND_W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_sn),
    .ring_size (cfg_ring_size),
    .db_valid  (db_valid),
    .db_count  (db_count),
    .take      (take),
    .head      (head_ptr),
    .pend      (pend_cnt)
  );

  // current instruction
  aq_cmd_t       cmd_q;
  logic [RW-1:0] ra_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      cmd_q <= '0;
      ra_q  <= '0;
    end else if (take) begin
      cmd_q <= cmd_mem[slot];
      ra_q  <= ra_mem[slot];
    end
  end

  // type decode: four held tables
  logic       type_ok, idx_ok;
  logic [1:0] tab_sel;

  always_comb begin
    type_ok = 1'b1;
    tab_sel = 2'd0;
    case (cmd_q.ctype)
      4'd0:    tab_sel = 2'd0;
      4'd1:    tab_sel = 2'd1;
      4'd2:    tab_sel = 2'd2;
      4'd4:    tab_sel = 2'd3;
      default: type_ok = 1'b0;
    endcase
  end
  assign idx_ok = (cmd_q.cidx < 20'(CTX_NUM));

  // result memory ports: 0 software, 1 data word, 2 mask word
  logic [2:0][RW-1:0] rd_addr;
  logic [2:0][63:0]   rd_data;
  logic               eng_we;
  logic [RW-1:0]      eng_addr;
  logic [63:0]        eng_data;

  assign rd_addr[0] = res_rd_addr;
  assign rd_addr[1] = ra_q + RW'(DATA_OFS);
  assign rd_addr[2] = ra_q + RW'(MASK_OFS);
  assign res_rd_data = rd_data[0];

  aq_result_ram #(.DEPTH(RES_DEPTH), .NRD(3)) u_res (
    .clk      (clk),
    .sw_we    (res_wr_en),
    .sw_addr  (res_wr_addr),
    .sw_data  (res_wr_data),
    .eng_we   (eng_we),
    .eng_addr (eng_addr),
    .eng_data (eng_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  // context store
  logic [63:0] ctx_rdata, ctx_wdata;
  logic        ctx_valid, ctx_we, ret_we, exec_en;
  logic [7:0]  code_d, code_q;

  aq_ctx_store #(.CTX_NUM(CTX_NUM), .NTAB(4)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_sn),
    .sel      (tab_sel),
    .idx      (cmd_q.cidx[CW-1:0]),
    .rd_data  (ctx_rdata),
    .rd_valid (ctx_valid),
    .we       (ctx_we),
    .wr_data  (ctx_wdata)
  );

  // operation execution
  assign exec_en = (state_q == ST_EXEC);

  always_comb begin
    code_d    = CC_GOOD;
    ctx_we    = 1'b0;
    ret_we    = 1'b0;
    ctx_wdata = rd_data[1];
    case (cmd_q.opc)
      OP_NOP, OP_LOCK, OP_UNLOCK: code_d = CC_GOOD;
      OP_INIT: begin
        if (type_ok && idx_ok) ctx_we = exec_en;
        else                   code_d = CC_SWERR;
      end
      OP_WRITE: begin
        ctx_wdata = (ctx_rdata & ~rd_data[2]) | (rd_data[1] & rd_data[2]);
        if (type_ok && idx_ok && ctx_valid) ctx_we = exec_en;
        else                                code_d = CC_SWERR;
      end
      OP_READ: begin
        if (type_ok && idx_ok && ctx_valid) ret_we = exec_en;
        else                                code_d = CC_SWERR;
      end
      default: code_d = CC_SWERR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      code_q <= CC_NOTDONE;
    else if (exec_en) code_q <= code_d;
  end

  // engine writes into the result memory
  always_comb begin
    eng_we   = 1'b0;
    eng_addr = ra_q;
    eng_data = mk_header(cmd_q.opc, cmd_q.ctype, CC_NOTDONE, cmd_q.irq_req);
    case (state_q)
      ST_STAMP: eng_we = 1'b1;
      ST_EXEC: begin
        eng_we   = ret_we;
        eng_addr = rd_addr[1];
        eng_data = ctx_rdata;
      end
      ST_FIN: begin
        eng_we   = 1'b1;
        eng_data = mk_header(cmd_q.opc, cmd_q.ctype, code_q, cmd_q.irq_req);
      end
      default: eng_we = 1'b0;
    endcase
  end

  // sequencing
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (take) state_d = ST_STAMP;
      ST_STAMP: state_d = ST_EXEC;
      ST_EXEC:  state_d = ST_FIN;
      default:  state_d = ST_IDLE;
    endcase
  end

  logic irq_d, irq_q;
  assign irq_d = (state_q == ST_FIN) && cmd_q.irq_req;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done_irq = irq_q;

endmodule

// File: rtl/ctx_aq_chk.sv
module ctx_aq_chk #(
  parameter int IW = 4,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done_irq,
  input logic [IW-1:0] head_ptr,
  input logic [PW-1:0] pend_cnt,
  input logic [IW:0]   cfg_ring_size,
  input logic          db_valid,
  input logic          ctx_we
);

  a_r2_start_when_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pend_cnt != '0) |=> busy);

  a_r2_pend_step: assert property (@(posedge clk) disable iff (!rst_n)
    !db_valid |=> (pend_cnt == $past(pend_cnt) || pend_cnt == $past(pend_cnt) - PW'(1)));

  a_r10_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  a_r10_irq_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);

  a_r11_head_moves_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(head_ptr) |-> busy);

  a_r11_head_in_ring: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(head_ptr) |-> (head_ptr == '0 || {1'b0, head_ptr} < cfg_ring_size));

  a_r8_store_write_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_we |-> busy);

endmodule

bind ctx_aq_engine ctx_aq_chk #(.IW(IW), .PW(PEND_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .done_irq      (done_irq),
  .head_ptr      (head_ptr),
  .pend_cnt      (pend_cnt),
  .cfg_ring_size (cfg_ring_size),
  .db_valid      (db_valid),
  .ctx_we        (ctx_we)
);

// File: tb/ctx_aq_engine_tb.sv
`timescale 1ns/1ps
module ctx_aq_engine_tb;

  localparam int ID = 8;
  localparam int CN = 4;
  localparam int RD = 64;
  localparam int PW = 8;
  localparam int IW = 3;
  localparam int RW = 6;
  localparam int RBASE = 6;
  localparam int RSIZE = 3;

  logic          clk, rst_n;
  logic [IW-1:0] cfg_ring_base;
  logic [IW:0]   cfg_ring_size;
  logic          db_valid;
  logic [PW-1:0] db_count;
  logic          inst_wr_en;
  logic [IW-1:0] inst_wr_idx;
  logic [63:0]   inst_wr_w0, inst_wr_w1;
  logic          res_wr_en;
  logic [RW-1:0] res_wr_addr, res_rd_addr;
  logic [63:0]   res_wr_data, res_rd_data;
  logic          busy, done_irq;
  logic [IW-1:0] head_ptr;
  logic [PW-1:0] pend_cnt;

  ctx_aq_engine #(.INST_DEPTH(ID), .CTX_NUM(CN), .RES_DEPTH(RD), .PEND_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_ring_size(cfg_ring_size),
    .db_valid(db_valid), .db_count(db_count), .inst_wr_en(inst_wr_en), .inst_wr_idx(inst_wr_idx),
    .inst_wr_w0(inst_wr_w0), .inst_wr_w1(inst_wr_w1), .res_wr_en(res_wr_en),
    .res_wr_addr(res_wr_addr), .res_wr_data(res_wr_data), .res_rd_addr(res_rd_addr),
    .res_rd_data(res_rd_data), .busy(busy), .head_ptr(head_ptr), .pend_cnt(pend_cnt),
    .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, irq_cnt = 0, sw_tail = 0;
  bit run = 0, res_init = 0, done_flag = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] hdr(input int op, input int ct, input int cc, input int di);
    return {47'd0, di[0], cc[7:0], ct[3:0], op[3:0]};
  endfunction

  function automatic logic [63:0] mk_w0(input int op, input int ct, input int ci, input int di);
    return {di[0], 19'd0, ci[19:0], 9'd0, 7'h55, ct[3:0], op[3:0]};
  endfunction

  // behavioural reference model
  logic [63:0]  m_res [RD];
  logic [127:0] m_inst [ID];
  logic [63:0]  m_ctx [4][CN];
  bit           m_val [4][CN];
  int m_phase, m_head, m_pend, m_dec, m_op, m_ct, m_ci, m_di, m_ra, m_sel, m_code;
  bit m_irq, m_ok;
  logic [127:0] m_cur;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_head = 0; m_pend = 0; m_irq = 0;
      for (int t = 0; t < 4; t++) for (int i = 0; i < CN; i++) m_val[t][i] = 0;
    end else begin
      m_dec = 0;
      m_irq = 0;
      if (inst_wr_en) m_inst[inst_wr_idx] = {inst_wr_w1, inst_wr_w0};
      if (res_wr_en)  m_res[res_wr_addr]  = res_wr_data;
      case (m_phase)
        0: if (m_pend > 0) begin
             m_cur  = m_inst[(int'(cfg_ring_base) + m_head) % ID];
             m_op   = int'(m_cur[3:0]);
             m_ct   = int'(m_cur[7:4]);
             m_ci   = int'(m_cur[43:24]);
             m_di   = int'(m_cur[63]);
             m_ra   = int'(m_cur[64+3 +: RW]);
             m_head = (m_head + 1 >= int'(cfg_ring_size)) ? 0 : m_head + 1;
             m_dec  = 1;
             m_phase = 1;
           end
        1: begin m_res[m_ra] = hdr(m_op, m_ct, 0, m_di); m_phase = 2; end
        2: begin
             m_sel = (m_ct <= 2) ? m_ct : (m_ct == 4) ? 3 : -1;
             m_ok  = (m_sel >= 0) && (m_ci < CN);
             m_code = 2;
             case (m_op)
               0, 4, 5: m_code = 1;
               1: if (m_ok) begin
                    m_ctx[m_sel][m_ci] = m_res[(m_ra + 16) % RD];
                    m_val[m_sel][m_ci] = 1; m_code = 1;
                  end
               2: if (m_ok && m_val[m_sel][m_ci]) begin
                    m_ctx[m_sel][m_ci] = (m_ctx[m_sel][m_ci] & ~m_res[(m_ra + 32) % RD]) |
                                         (m_res[(m_ra + 16) % RD] & m_res[(m_ra + 32) % RD]);
                    m_code = 1;
                  end
               3: if (m_ok && m_val[m_sel][m_ci]) begin
                    m_res[(m_ra + 16) % RD] = m_ctx[m_sel][m_ci];
                    m_code = 1;
                  end
               default: m_code = 2;
             endcase
             m_phase = 3;
           end
        default: begin
             m_res[m_ra] = hdr(m_op, m_ct, m_code, m_di);
             m_irq = (m_di != 0);
             m_phase = 0;
           end
      endcase
      if (db_valid) m_pend = m_pend + int'(db_count);
      m_pend = (m_pend - m_dec) % 256;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && run) begin
      chk("R2 busy", {63'd0, busy}, {63'd0, (m_phase != 0)});
      chk("R11 head_ptr", 64'(head_ptr), 64'(m_head));
      chk("R11 pend_cnt", 64'(pend_cnt), 64'(m_pend));
      chk("R10 done_irq", {63'd0, done_irq}, {63'd0, m_irq});
      if (res_init) chk("R3/R4 result word", res_rd_data, m_res[res_rd_addr]);
      if (done_irq) irq_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done_flag) begin
      done_flag = 1;
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected<50000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic put_res(input int a, input logic [63:0] d);
    @(negedge clk); #1;
    res_wr_en = 1; res_wr_addr = RW'(a); res_wr_data = d;
    @(negedge clk); #1;
    res_wr_en = 0;
  endtask

  task automatic submit(input logic [63:0] w0, input int word);
    @(negedge clk); #1;
    inst_wr_en = 1; inst_wr_idx = IW'((RBASE + sw_tail) % ID);
    inst_wr_w0 = w0; inst_wr_w1 = 64'(word * 8) | 64'h5;
    sw_tail = (sw_tail + 1) % RSIZE;
    @(negedge clk); #1;
    inst_wr_en = 0;
  endtask

  task automatic ring(input int n);
    @(negedge clk); #1;
    db_valid = 1; db_count = PW'(n);
    @(negedge clk); #1;
    db_valid = 0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_phase != 0 || m_pend != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [63:0] v);
    @(negedge clk); #1;
    res_rd_addr = RW'(a);
    #1 v = res_rd_data;
  endtask

  logic [63:0] v;

  initial begin
    rst_n = 0; cfg_ring_base = IW'(RBASE); cfg_ring_size = (IW+1)'(RSIZE);
    db_valid = 0; db_count = 0; inst_wr_en = 0; inst_wr_idx = 0; inst_wr_w0 = 0; inst_wr_w1 = 0;
    res_wr_en = 0; res_wr_addr = 0; res_wr_data = 0; res_rd_addr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk("R2 reset busy", {63'd0, busy}, 64'd0);
    chk("R2 reset head", 64'(head_ptr), 64'd0);
    chk("R2 reset pend", 64'(pend_cnt), 64'd0);
    chk("R2 reset irq", {63'd0, done_irq}, 64'd0);
    run = 1;
    for (int i = 0; i < RD; i++) put_res(i, 64'hDEAD_0000_0000_0000 | 64'(i));
    res_init = 1;

    // R5: initialise receive context 1 with irq
    put_res(16, 64'h1122_3344_5566_7788);
    submit(mk_w0(1, 0, 1, 1), 0);
    ring(1); wait_idle();
    rd(0, v); chk("R5 init header", v, 64'h0000_0000_0001_0101);
    chk("R10 one irq pulse", 64'(irq_cnt), 64'd1);

    // R6/R7: masked write then read back, one batch
    put_res(17, 64'hFFFF_0000_FFFF_0000);
    put_res(33, 64'h0000_0000_FFFF_FFFF);
    submit(mk_w0(2, 0, 1, 0), 1);
    submit(mk_w0(3, 0, 1, 0), 2);
    ring(2); wait_idle();
    rd(1, v);  chk("R6 write header", v, 64'h0102);
    rd(2, v);  chk("R7 read header", v, 64'h0103);
    rd(18, v); chk("R6 merged context read by R7", v, 64'h1122_3344_FFFF_0000);
    chk("R10 no irq without flag", 64'(irq_cnt), 64'd1);

    // R8: read of never initialised send context
    submit(mk_w0(3, 1, 1, 0), 3);
    ring(1); wait_idle();
    rd(3, v);  chk("R8 uninit read header", v, 64'h0213);
    rd(19, v); chk("R8 data word untouched", v, 64'hDEAD_0000_0000_0013);

    // R12/R8: unheld type, out-of-range index, alias probe; doorbells while busy
    submit(mk_w0(1, 3, 0, 0), 4);
    submit(mk_w0(1, 0, 4, 0), 5);
    submit(mk_w0(3, 0, 0, 0), 6);
    ring(1); ring(1); ring(1); wait_idle();
    rd(4, v); chk("R12 type 3 not held", v, 64'h0231);
    rd(5, v); chk("R8 index at CTX_NUM", v, 64'h0201);
    rd(6, v); chk("R8 entry 0 still invalid", v, 64'h0203);
    rd(22, v); chk("R8 read fail leaves data word", v, 64'hDEAD_0000_0000_0016);

    // R9/R1: undefined opcode, no-op with irq, lock
    submit(mk_w0(7, 0, 0, 0), 7);
    submit(mk_w0(0, 0, 0, 1), 8);
    submit(mk_w0(4, 2, 0, 0), 9);
    ring(3); wait_idle();
    rd(7, v); chk("R1 undefined opcode", v, 64'h0207);
    rd(8, v); chk("R9 no-op with irq", v, 64'h0001_0100);
    rd(9, v); chk("R9 lock", v, 64'h0124);
    chk("R10 irq count", 64'(irq_cnt), 64'd2);

    // R12: hash table at last index, separate from receive table
    put_res(26, 64'hCAFE_F00D_0BAD_BEEF);
    submit(mk_w0(1, 4, 3, 0), 10);
    submit(mk_w0(3, 4, 3, 0), 11);
    submit(mk_w0(3, 0, 1, 0), 12);
    ring(3); wait_idle();
    rd(11, v); chk("R12 hash read header", v, 64'h0143);
    rd(27, v); chk("R12 hash context", v, 64'hCAFE_F00D_0BAD_BEEF);
    rd(28, v); chk("R12 receive context kept", v, 64'h1122_3344_FFFF_0000);
    submit(mk_w0(3, 5, 0, 0), 13);
    ring(1); wait_idle();
    rd(13, v); chk("R12 type 5 not held", v, 64'h0253);

    // R3: not-done stamp visible during execution
    put_res(30, 64'h0);
    @(negedge clk); #1 res_rd_addr = RW'(14);
    submit(mk_w0(1, 0, 2, 1), 14);
    ring(1);
    do @(negedge clk); while (m_phase != 2);
    #1 chk("R3 not-done stamp", res_rd_data, 64'h0001_0001);
    wait_idle();
    rd(14, v); chk("R3 final after stamp", v, 64'h0001_0101);

    // R11: 15 instructions through a ring of 3
    chk("R11 head after wrap", 64'(head_ptr), 64'd0);
    chk("R11 nothing pending", 64'(pend_cnt), 64'd0);

    run = 0;
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule